// File: doc/BRIEF.md
# SMI Capability Lock and APM Command Dispatcher

This block runs a one-time handshake between firmware and the platform over which system-management-interrupt (SMI) features get used. The platform presents a 64-bit mask of the features it supports. Firmware assembles a 64-bit request one byte at a time, then issues a confirm write. In the cycle of that confirm write the block checks the request against the supported mask and against the dependency rules between feature bits. A request that passes is copied into a frozen negotiated set, and the lock flag goes high. A request that fails leaves the lock flag low, so firmware can try again. Once the lock is set it cannot be undone; only reset clears it.

After negotiation, firmware writes command bytes to the power-management command port. Two reserved command values switch the ACPI enable state on and off. Every other value is a request for an SMI. The block turns such a request into single-cycle pulses, one output per CPU. The pulse goes to the issuing CPU alone, or to all CPUs when broadcast was negotiated. The APM-command enable input must be high for any SMI to be produced.

Top module: `smi_cap_gate`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the requested mask, the lock flag, the negotiated set, the ACPI enable state and every SMI output are all zero.
- R2: A byte write with index k (0 to 7) replaces bits 8k+7 down to 8k of the requested mask (little-endian) and leaves the other bits unchanged. The result is visible on the next clock.
- R3: Feature bit 0 is broadcast, bit 1 is CPU hotplug and bit 2 is CPU hot-unplug. A confirm write with a valid request sets the lock flag on the next clock and copies the request into the negotiated set. A request of all zeros is valid.
- R4: A request with any bit set that is absent from the supported mask is rejected. The lock flag stays 0 and the negotiated set stays 0.
- R5: A request with hotplug or hot-unplug set but broadcast clear is rejected.
- R6: A request with hot-unplug set and hotplug clear is rejected.
- R7: Once the lock flag is 1, further confirm writes and changes to the requested mask have no effect on the lock flag or on the negotiated set until reset.
- R8: Command 8'hE1 sets the ACPI enable state and command 8'hE0 clears it. Neither command produces an SMI, whatever the enable input is.
- R9: Any other command written while the APM-command enable is high gives a one-cycle pulse, on the next clock, on the output of the issuing CPU only, provided broadcast is not negotiated. With the enable low, no pulse is produced.
- R10: When the negotiated set contains broadcast, such a command pulses every SMI output in the same cycle.
- R11: A confirm write is judged on the requested mask as it stood before that clock edge. An APM command is steered by the negotiated set as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_caps_i | input | 64 | Features supported by the platform, held static |
| req_wr_i | input | 1 | Byte write strobe for the requested mask |
| req_idx_i | input | 3 | Byte index within the requested mask |
| req_byte_i | input | 8 | Byte value to write |
| ok_wr_i | input | 1 | Confirm write: validate and try to lock |
| apm_wr_i | input | 1 | Command port write strobe |
| apm_cmd_i | input | 8 | Command byte |
| apmc_en_i | input | 1 | APM-command SMI enable |
| cur_cpu_i | input | 2 | Index of the CPU issuing the command |
| req_mask_o | output | 64 | Requested mask readback |
| feat_ok_o | output | 1 | Lock flag |
| negotiated_o | output | 64 | Frozen negotiated feature set |
| acpi_en_o | output | 1 | ACPI enable state |
| smi_o | output | 4 | One-cycle SMI pulse per CPU |

## Verification
Two pairs of functions can land on one clock edge. In the first, a confirm write and a command write arrive together, with broadcast sitting in the request. The bench expects the SMI to reach only the issuing CPU, because steering uses the negotiated set from before the edge, and expects the lock to be taken in the same cycle. In the second, a byte write and a confirm write arrive together after reset. The bench expects the lock to capture the old all-zero request, not the byte that lands on that edge, and then expects later commands to go to a single CPU.

// File: rtl/smi_pkg.sv
// Shared constants and the request validation rule for the SMI capability lock.
// Assumes a feature mask that is a whole number of bytes.
package smi_pkg;
    parameter int FEAT_W  = 64;
    parameter int N_BYTES = FEAT_W / 8;
    parameter int IDX_W   = $clog2(N_BYTES);

    // Bit positions that firmware decodes
    parameter int FEAT_BCAST = 0;
    parameter int FEAT_HP    = 1;
    parameter int FEAT_HU    = 2;

    // True when a request is a subset of host features and obeys the dependency rules
    function automatic logic feat_req_ok(input logic [FEAT_W-1:0] req,
                                         input logic [FEAT_W-1:0] host);
        logic subset_ok;
        logic hp_any;
        subset_ok = ((req & ~host) == '0);
        hp_any    = req[FEAT_HP] | req[FEAT_HU];
        return subset_ok && (!hp_any || req[FEAT_BCAST]) &&
               (!req[FEAT_HU] || req[FEAT_HP]);
    endfunction
endpackage

// File: rtl/smi_req_bytes.sv
// Requested-feature mask held as byte registers, written one byte per cycle.
// Assumes byte index 0 holds the least significant byte (little-endian).
module smi_req_bytes
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [7:0]        byte_i,
    output logic [FEAT_W-1:0] mask_o
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        logic [7:0] byte_q;
        // Hold one byte of the request; replace it when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_i && (idx_i == IDX_W'(b))) begin
                byte_q <= byte_i;
            end
        end
        assign mask_o[8*b +: 8] = byte_q;
    end
endmodule

// File: rtl/smi_feat_lock.sv
// One-shot lock: validates the current request on a confirm write and freezes it.
// Assumes the host mask is static while out of reset.
module smi_feat_lock
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ok_wr_i,
    input  logic [FEAT_W-1:0] req_i,
    input  logic [FEAT_W-1:0] host_i,
    output logic              locked_o,
    output logic [FEAT_W-1:0] neg_o
);
    logic take;

    // Lock only when not yet locked and the request passes every rule
    assign take = ok_wr_i && !locked_o && feat_req_ok(req_i, host_i);

    // Latch the negotiated set and the lock flag exactly once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
            neg_o    <= '0;
        end else if (take) begin
            locked_o <= 1'b1;
            neg_o    <= req_i;
        end
    end
endmodule

// File: rtl/smi_apm_dispatch.sv
// Decodes command port writes: ACPI on/off commands, otherwise SMI pulses.
// Assumes cur_cpu_i indexes a CPU below NUM_CPUS; other values pulse nobody.
module smi_apm_dispatch #(
    parameter int         NUM_CPUS     = 4,
    parameter int         CPU_W        = 2,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0] ACPI_OFF_CMD = 8'hE0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [7:0]          cmd_i,
    input  logic                apmc_en_i,
    input  logic [CPU_W-1:0]    cpu_i,
    input  logic                bcast_i,
    output logic                acpi_en_o,
    output logic [NUM_CPUS-1:0] smi_o
);
    logic is_on, is_off, fire;
    logic [NUM_CPUS-1:0] smi_d;

    assign is_on  = (cmd_i == ACPI_ON_CMD);
    assign is_off = (cmd_i == ACPI_OFF_CMD);
    assign fire   = wr_i && apmc_en_i && !is_on && !is_off;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign smi_d[c] = fire && (bcast_i || (cpu_i == CPU_W'(c)));
    end

    // Track the ACPI enable state from the two reserved commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acpi_en_o <= 1'b0;
        end else if (wr_i && is_on) begin
            acpi_en_o <= 1'b1;
        end else if (wr_i && is_off) begin
            acpi_en_o <= 1'b0;
        end
    end

    // Register the SMI pulses so each lasts one cycle per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_o <= '0;
        end else begin
            smi_o <= smi_d;
        end
    end
endmodule

// File: rtl/smi_cap_gate.sv
// Top: request bytes, one-shot validated lock, and APM command to SMI dispatch.
// Assumes host_caps_i is static after reset; CPU interrupt delivery is external.
module smi_cap_gate
    import smi_pkg::*;
#(
    parameter int         NUM_CPUS     = 4,
    parameter int         CPU_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0] ACPI_OFF_CMD = 8'hE0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FEAT_W-1:0]   host_caps_i,
    input  logic                req_wr_i,
    input  logic [IDX_W-1:0]    req_idx_i,
    input  logic [7:0]          req_byte_i,
    input  logic                ok_wr_i,
    input  logic                apm_wr_i,
    input  logic [7:0]          apm_cmd_i,
    input  logic                apmc_en_i,
    input  logic [CPU_W-1:0]    cur_cpu_i,
    output logic [FEAT_W-1:0]   req_mask_o,
    output logic                feat_ok_o,
    output logic [FEAT_W-1:0]   negotiated_o,
    output logic                acpi_en_o,
    output logic [NUM_CPUS-1:0] smi_o
);
    smi_req_bytes u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (req_wr_i),
        .idx_i  (req_idx_i),
        .byte_i (req_byte_i),
        .mask_o (req_mask_o)
    );

    smi_feat_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ok_wr_i  (ok_wr_i),
        .req_i    (req_mask_o),
        .host_i   (host_caps_i),
        .locked_o (feat_ok_o),
        .neg_o    (negotiated_o)
    );

    smi_apm_dispatch #(
        .NUM_CPUS     (NUM_CPUS),
        .CPU_W        (CPU_W),
        .ACPI_ON_CMD  (ACPI_ON_CMD),
        .ACPI_OFF_CMD (ACPI_OFF_CMD)
    ) u_apm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (apm_wr_i),
        .cmd_i     (apm_cmd_i),
        .apmc_en_i (apmc_en_i),
        .cpu_i     (cur_cpu_i),
        .bcast_i   (negotiated_o[FEAT_BCAST]),
        .acpi_en_o (acpi_en_o),
        .smi_o     (smi_o)
    );
endmodule

// File: rtl/smi_cap_gate_chk.sv
// Assertion checker for smi_cap_gate, attached with bind.
module smi_cap_gate_chk
    import smi_pkg::*;
#(
    parameter int         NUM_CPUS     = 4,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hE1,
    parameter logic [7:0] ACPI_OFF_CMD = 8'hE0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [FEAT_W-1:0]   host_caps_i,
    input logic                ok_wr_i,
    input logic                apm_wr_i,
    input logic [7:0]          apm_cmd_i,
    input logic                apmc_en_i,
    input logic                feat_ok_o,
    input logic [FEAT_W-1:0]   negotiated_o,
    input logic [NUM_CPUS-1:0] smi_o
);
    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok_o |=> (feat_ok_o && negotiated_o == $past(negotiated_o)));

    // R3
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feat_ok_o) |-> $past(ok_wr_i));

    // R4
    subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok_o |-> ((negotiated_o & ~host_caps_i) == '0));

    // R5
    hp_needs_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_ok_o && (negotiated_o[FEAT_HP] || negotiated_o[FEAT_HU]))
            |-> negotiated_o[FEAT_BCAST]);

    // R6
    hu_needs_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_ok_o && negotiated_o[FEAT_HU]) |-> negotiated_o[FEAT_HP]);

    // R8
    acpi_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && (apm_cmd_i == ACPI_ON_CMD || apm_cmd_i == ACPI_OFF_CMD))
            |=> (smi_o == '0));

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o != '0) |-> $past(apm_wr_i && apmc_en_i));

    // R9
    single_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((smi_o != '0) && !$past(negotiated_o[FEAT_BCAST])) |-> ($countones(smi_o) == 1));

    // R10
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((smi_o != '0) && $past(negotiated_o[FEAT_BCAST])) |-> (&smi_o));
endmodule

bind smi_cap_gate smi_cap_gate_chk #(
    .NUM_CPUS     (NUM_CPUS),
    .ACPI_ON_CMD  (ACPI_ON_CMD),
    .ACPI_OFF_CMD (ACPI_OFF_CMD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_caps_i  (host_caps_i),
    .ok_wr_i      (ok_wr_i),
    .apm_wr_i     (apm_wr_i),
    .apm_cmd_i    (apm_cmd_i),
    .apmc_en_i    (apmc_en_i),
    .feat_ok_o    (feat_ok_o),
    .negotiated_o (negotiated_o),
    .smi_o        (smi_o)
);

// File: tb/smi_cap_gate_bench.sv
module smi_cap_gate_bench;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] host_caps = 64'h7;
    logic        req_wr = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [7:0]  req_byte = '0;
    logic        ok_wr = 1'b0;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_cmd = '0;
    logic        apmc_en = 1'b0;
    logic [1:0]  cur_cpu = '0;
    logic [63:0] req_mask, negotiated;
    logic        feat_ok, acpi_en;
    logic [NC-1:0] smi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [NC-1:0] exp; string tag; } smi_item_t;
    smi_item_t sb_q[$];

    always #10 clk = ~clk;

    smi_cap_gate #(.NUM_CPUS(NC)) u_smi_cap_gate (
        .clk(clk), .rst_n(rst_n), .host_caps_i(host_caps),
        .req_wr_i(req_wr), .req_idx_i(req_idx), .req_byte_i(req_byte),
        .ok_wr_i(ok_wr), .apm_wr_i(apm_wr), .apm_cmd_i(apm_cmd),
        .apmc_en_i(apmc_en), .cur_cpu_i(cur_cpu),
        .req_mask_o(req_mask), .feat_ok_o(feat_ok), .negotiated_o(negotiated),
        .acpi_en_o(acpi_en), .smi_o(smi)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected SMI vector per cycle while items are queued
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                smi_item_t it;
                it = sb_q.pop_front();
                check(it.tag, 64'(smi), 64'(it.exp));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_wr = 0; ok_wr = 0; apm_wr = 0; apmc_en = 0;
        repeat (2) @(negedge clk);
        check("R1 smi in reset", 64'(smi), 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        req_wr = 1'b1; req_idx = idx; req_byte = val;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic confirm();
        @(negedge clk);
        ok_wr = 1'b1;
        @(negedge clk);
        ok_wr = 1'b0;
    endtask

    // Driver: one command write, then an idle cycle; expectations go to the scoreboard
    task automatic apm(input logic [7:0] cmd, input logic en, input logic [1:0] cpu,
                       input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        apm_wr = 1'b1; apm_cmd = cmd; apmc_en = en; cur_cpu = cpu;
        @(posedge clk);
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        apm_wr = 1'b0;
        @(posedge clk);
        sb_q.push_back('{'0, {tag, " pulse width"}});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 req", req_mask, 64'h0);
        check("R1 ok", 64'(feat_ok), 64'h0);
        check("R1 neg", negotiated, 64'h0);
        check("R1 acpi", 64'(acpi_en), 64'h0);

        wr_byte(3'd5, 8'hA5);
        check("R2 byte5", req_mask, 64'h0000_A500_0000_0000);
        wr_byte(3'd0, 8'h3C);
        check("R2 byte0", req_mask, 64'h0000_A500_0000_003C);
        confirm();
        check("R4 unsupported ok", 64'(feat_ok), 64'h0);
        check("R4 unsupported neg", negotiated, 64'h0);

        wr_byte(3'd5, 8'h00);
        wr_byte(3'd0, 8'h02);
        confirm();
        check("R5 hotplug no bcast", 64'(feat_ok), 64'h0);
        wr_byte(3'd0, 8'h04);
        confirm();
        check("R5 unplug alone", 64'(feat_ok), 64'h0);
        wr_byte(3'd0, 8'h05);
        confirm();
        check("R6 unplug no hotplug", 64'(feat_ok), 64'h0);

        apm(8'h40, 1'b1, 2'd2, 4'b0100, "R9 single cpu2");
        apm(8'h40, 1'b0, 2'd2, 4'b0000, "R9 enable low");
        apm(8'hE1, 1'b1, 2'd0, 4'b0000, "R8 acpi on no smi");
        @(negedge clk);
        check("R8 acpi on", 64'(acpi_en), 64'h1);
        apm(8'hE0, 1'b1, 2'd0, 4'b0000, "R8 acpi off no smi");
        @(negedge clk);
        check("R8 acpi off", 64'(acpi_en), 64'h0);

        // R11: confirm and command in the same cycle, broadcast pending
        wr_byte(3'd0, 8'h01);
        @(negedge clk);
        ok_wr = 1'b1; apm_wr = 1'b1; apm_cmd = 8'h40; apmc_en = 1'b1; cur_cpu = 2'd1;
        @(posedge clk);
        sb_q.push_back('{4'b0010, "R11 steer by old set"});
        @(negedge clk);
        ok_wr = 1'b0; apm_wr = 1'b0;
        check("R3 lock bcast ok", 64'(feat_ok), 64'h1);
        check("R3 lock bcast neg", negotiated, 64'h1);

        apm(8'h55, 1'b1, 2'd3, 4'b1111, "R10 broadcast");
        wr_byte(3'd0, 8'h07);
        confirm();
        check("R7 frozen neg", negotiated, 64'h1);
        check("R7 frozen ok", 64'(feat_ok), 64'h1);

        do_reset();
        @(negedge clk);
        check("R1 after relock reset", negotiated, 64'h0);
        wr_byte(3'd0, 8'h07);
        confirm();
        check("R3 hotplug set ok", 64'(feat_ok), 64'h1);
        check("R3 hotplug set neg", negotiated, 64'h7);

        // R11: byte write and confirm in the same cycle lock the old all-zero request
        do_reset();
        @(negedge clk);
        req_wr = 1'b1; req_idx = 3'd0; req_byte = 8'h01; ok_wr = 1'b1;
        @(negedge clk);
        req_wr = 1'b0; ok_wr = 1'b0;
        check("R11 zero lock ok", 64'(feat_ok), 64'h1);
        check("R11 zero lock neg", negotiated, 64'h0);
        apm(8'h40, 1'b1, 2'd0, 4'b0001, "R11 zero set single cpu");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule